// File: doc/BRIEF.md
# Fully Associative Read Cache Lookup

This block holds a small set of cache lines, each carrying sixteen bytes of data, a 28-bit tag and a valid flag. Any line may hold any sixteen-byte block of a 32-bit address space. A lookup address is compared against every line in the same cycle. The single hit flag comes from the per-line match results, and the byte picked out by the low address bits of the matching line appears on the output with no clock delay.

After a miss, the surrounding controller fetches the line from memory and presents it on the fill port together with the miss address. The block then picks a slot on its own. A line that already holds the same tag is overwritten in place. Otherwise the lowest-numbered empty line is used. Once all lines are full, the line that was loaded longest ago is replaced, and a round-robin age pointer keeps track of which line that is. Writes from the processor side and any memory sequencing stay outside this block.

Top module: `fa_cache_lookup`

## Requirements
- R1: After reset every line is empty. Every lookup then misses, with lkp_hit=0, lkp_line=0 and lkp_byte=0, and fill_slot reads 0.
- R2: Address bits [31:4] are the tag and bits [3:0] are the byte offset. On a hit, lkp_byte is bits [8*off+7 : 8*off] of the matching line's 128-bit data. On a miss it is 0.
- R3: lkp_hit is 1 exactly when some line is valid and its tag equals lkp_addr[31:4]. The lookup is combinational, so it reflects lkp_addr in the same cycle.
- R4: On a hit, lkp_line gives the index of the matching line. On a miss it is 0.
- R5: When fill_en is high at a rising clock edge, the line at fill_slot takes tag fill_addr[31:4] and data fill_data and becomes valid. A lookup of that tag hits from the next cycle on.
- R6: While any line is empty and the fill tag is not already present, fill_slot is the lowest-numbered empty line, and the age pointer does not move.
- R7: When all lines are valid and the fill tag is not present, fill_slot equals the age pointer. The pointer starts at 0 and, after the fill, steps to the next index, wrapping from LINES-1 to 0. Evictions therefore follow load order.
- R8: A fill whose tag matches a valid line goes to that line and replaces its data. The age pointer is unchanged, and no two valid lines ever hold the same tag.
- R9: fill_slot is combinational from fill_addr and the line state, and shows the slot the next fill would write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_addr | input | 32 | Lookup byte address |
| lkp_hit | output | 1 | A valid line holds the lookup tag |
| lkp_line | output | $clog2(LINES) | Index of the matching line, 0 on miss |
| lkp_byte | output | 8 | Selected byte of the matching line, 0 on miss |
| fill_en | input | 1 | Write a line this cycle |
| fill_addr | input | 32 | Address of the block being filled (bits [3:0] unused) |
| fill_data | input | 128 | Line data, byte k in bits [8k+7:8k] |
| fill_slot | output | $clog2(LINES) | Slot the fill on this cycle writes |

## Verification
The bench runs four lines with a sweep of every byte offset of every resident line, using a distinct data pattern per fill so that a wrong line and a wrong byte each give a different value. Lookups of tags that were never loaded, and of tags that have been evicted, separate a real tag compare from a valid-only or partial compare. A run of new tags well past capacity checks the strict load-order rotation and its wrap-around. Refills of resident tags, placed both in the empty phase and in the full phase, show whether the in-place overwrite path takes priority and leaves the pointer alone.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;
  localparam int ADDR_W  = 32;
  localparam int OFF_W   = 4;
  localparam int TAG_W   = ADDR_W - OFF_W;
  localparam int LINE_B  = 1 << OFF_W;
  localparam int LINE_W  = LINE_B * 8;

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] addr_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic [7:0] pick_byte(input logic [LINE_W-1:0] d,
                                           input logic [OFF_W-1:0] off);
    return d[8*off +: 8];
  endfunction

  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match
  import fa_cache_pkg::*;
#(
  parameter int LINES = 4
) (
  input  logic [LINES-1:0][TAG_W-1:0] tags,
  input  logic [LINES-1:0]            valid,
  input  logic [TAG_W-1:0]            req_tag,
  output logic [LINES-1:0]            match
);
  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == req_tag);
  end
endmodule

// File: rtl/fa_match_encode.sv
module fa_match_encode #(
  parameter int LINES = 4,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] match,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |match;
    idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/fa_victim_sel.sv
module fa_victim_sel #(
  parameter int LINES = 4,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] valid,
  input  logic [LINES-1:0] same_tag,
  input  logic [IDX_W-1:0] age_ptr,
  output logic [IDX_W-1:0] slot,
  output logic             dup,
  output logic             use_age
);
  logic             have_free;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] dup_idx;
  logic             dup_any;

  fa_match_encode #(.LINES(LINES)) u_free (
    .match(~valid), .any(have_free), .idx(free_idx)
  );
  fa_match_encode #(.LINES(LINES)) u_dup (
    .match(same_tag), .any(dup_any), .idx(dup_idx)
  );

  always_comb begin
    dup     = dup_any;
    use_age = 1'b0;
    if (dup_any)        slot = dup_idx;
    else if (have_free) slot = free_idx;
    else begin
      slot    = age_ptr;
      use_age = 1'b1;
    end
  end
endmodule

// File: rtl/fa_cache_lookup.sv
module fa_cache_lookup
  import fa_cache_pkg::*;
#(
  parameter int LINES = 4,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     lkp_addr,
  output logic                  lkp_hit,
  output logic [IDX_W-1:0]      lkp_line,
  output logic [7:0]            lkp_byte,
  input  logic                  fill_en,
  input  logic [ADDR_W-1:0]     fill_addr,
  input  logic [LINE_W-1:0]     fill_data,
  output logic [IDX_W-1:0]      fill_slot
);
  logic [LINES-1:0][TAG_W-1:0]  line_tag;
  logic [LINES-1:0][LINE_W-1:0] line_data;
  logic [LINES-1:0]             line_valid;
  logic [IDX_W-1:0]             fifo_ptr;

  logic [LINES-1:0] look_match;
  logic [LINES-1:0] fill_match;
  logic             fill_dup;
  logic             fill_age;
  logic             fill_bump;
  logic             look_any;
  logic [IDX_W-1:0] look_idx;

  fa_tag_match #(.LINES(LINES)) u_look_cmp (
    .tags(line_tag), .valid(line_valid),
    .req_tag(addr_tag(lkp_addr)), .match(look_match)
  );

  fa_tag_match #(.LINES(LINES)) u_fill_cmp (
    .tags(line_tag), .valid(line_valid),
    .req_tag(addr_tag(fill_addr)), .match(fill_match)
  );

  fa_match_encode #(.LINES(LINES)) u_look_enc (
    .match(look_match), .any(look_any), .idx(look_idx)
  );

  fa_victim_sel #(.LINES(LINES)) u_victim (
    .valid(line_valid), .same_tag(fill_match), .age_ptr(fifo_ptr),
    .slot(fill_slot), .dup(fill_dup), .use_age(fill_age)
  );

  assign fill_bump = fill_en && fill_age;

  assign lkp_hit  = look_any;
  assign lkp_line = look_idx;
  assign lkp_byte = look_any ? pick_byte(line_data[look_idx], addr_off(lkp_addr)) : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_valid <= '0;
      line_tag   <= '0;
      line_data  <= '0;
      fifo_ptr   <= '0;
    end else begin
      if (fill_en) begin
        line_valid[fill_slot] <= 1'b1;
        line_tag[fill_slot]   <= addr_tag(fill_addr);
        line_data[fill_slot]  <= fill_data;
      end
      if (fill_bump) fifo_ptr <= IDX_W'(ptr_next(int'(fifo_ptr), LINES));
    end
  end
endmodule

// File: rtl/fa_cache_lookup_chk.sv
module fa_cache_lookup_chk
  import fa_cache_pkg::*;
#(
  parameter int LINES = 4,
  localparam int IDX_W = $clog2(LINES)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        fill_en,
  input logic [ADDR_W-1:0]           fill_addr,
  input logic [IDX_W-1:0]            fill_slot,
  input logic                        lkp_hit,
  input logic [IDX_W-1:0]            lkp_line,
  input logic [LINES-1:0]            line_valid,
  input logic [LINES-1:0][TAG_W-1:0] line_tag,
  input logic [LINES-1:0]            look_match,
  input logic [IDX_W-1:0]            fifo_ptr,
  input logic                        fill_bump,
  input logic                        fill_dup
);
  // R1
  empty_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (line_valid == '0 && !lkp_hit));

  // R3
  hit_line_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_hit |-> line_valid[lkp_line]);

  // R8
  unique_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_match));

  // R5
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (line_valid[$past(fill_slot)] &&
                 line_tag[$past(fill_slot)] == $past(addr_tag(fill_addr))));

  // R6
  free_fill_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !fill_dup && !(&line_valid)) |=>
      ($countones(line_valid) == $past($countones(line_valid)) + 1 && $stable(fifo_ptr)));

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_bump |=> fifo_ptr == IDX_W'(ptr_next(int'($past(fifo_ptr)), LINES)));

  // R8
  dup_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && fill_dup) |=> ($stable(fifo_ptr) && $stable(line_valid)));
endmodule

bind fa_cache_lookup fa_cache_lookup_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_addr(fill_addr),
  .fill_slot(fill_slot), .lkp_hit(lkp_hit), .lkp_line(lkp_line),
  .line_valid(line_valid), .line_tag(line_tag), .look_match(look_match),
  .fifo_ptr(fifo_ptr), .fill_bump(fill_bump), .fill_dup(fill_dup)
);

// File: tb/test_fa_cache_lookup.sv
module test_fa_cache_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   lkp_addr = '0;
  logic          lkp_hit;
  logic [IW-1:0] lkp_line;
  logic [7:0]    lkp_byte;
  logic          fill_en = 1'b0;
  logic [31:0]   fill_addr = '0;
  logic [127:0]  fill_data = '0;
  logic [IW-1:0] fill_slot;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [27:0]  m_tag [N];
  logic [127:0] m_dat [N];
  bit           m_val [N];
  int           m_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  fa_cache_lookup #(.LINES(N)) i_fa_cache_lookup (
    .clk(clk), .rst_n(rst_n), .lkp_addr(lkp_addr), .lkp_hit(lkp_hit),
    .lkp_line(lkp_line), .lkp_byte(lkp_byte), .fill_en(fill_en),
    .fill_addr(fill_addr), .fill_data(fill_data), .fill_slot(fill_slot)
  );

  function automatic logic [127:0] pattern(input int seed);
    logic [127:0] d;
    for (int k = 0; k < 16; k++) d[8*k +: 8] = 8'((seed * 37 + k * 11 + 5) & 255);
    return d;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h time=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_slot(input logic [27:0] t);
    for (int i = 0; i < N; i++) if (m_val[i] && m_tag[i] == t) return i;
    for (int i = 0; i < N; i++) if (!m_val[i]) return i;
    return m_ptr;
  endfunction

  // lookup at current negedge-driven address, sampled 1 time unit later
  task automatic look(input logic [31:0] a, input string req);
    int hit_i;
    logic [7:0] eb;
    @(negedge clk);
    lkp_addr = a;
    #1;
    hit_i = -1;
    for (int i = 0; i < N; i++) if (m_val[i] && m_tag[i] == a[31:4]) hit_i = i;
    eb = (hit_i >= 0) ? m_dat[hit_i][8*a[3:0] +: 8] : 8'h00;
    check({req, " hit"}, lkp_hit, hit_i >= 0);
    check({req, " line"}, lkp_line, hit_i >= 0 ? hit_i : 0);
    check({req, " byte"}, lkp_byte, eb);
  endtask

  task automatic fill(input logic [31:0] a, input int seed, input string req);
    int s;
    bit all_full;
    bit dupl;
    @(negedge clk);
    fill_en = 1'b1;
    fill_addr = a;
    fill_data = pattern(seed);
    #1;
    s = model_slot(a[31:4]);
    check({req, " fill_slot"}, fill_slot, s);
    all_full = 1;
    dupl = 0;
    for (int i = 0; i < N; i++) begin
      if (!m_val[i]) all_full = 0;
      if (m_val[i] && m_tag[i] == a[31:4]) dupl = 1;
    end
    @(posedge clk);
    #1;
    fill_en = 1'b0;
    m_val[s] = 1;
    m_tag[s] = a[31:4];
    m_dat[s] = pattern(seed);
    if (all_full && !dupl) m_ptr = (m_ptr + 1) % N;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_val[i] = 0; m_tag[i] = '0; m_dat[i] = '0;
    end
    m_ptr = 0;
    #(CLK_PERIOD * 3);
    // R1: state during reset
    check("R1 hit in reset", lkp_hit, 0);
    check("R1 slot in reset", fill_slot, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: lookups after reset all miss
    look(32'h0000_0000, "R1");
    look(32'h1000_800C, "R1");
    look(32'hFFFF_FFFF, "R1");

    // R6: empty lines filled lowest first (R5 visibility)
    fill(32'h1000_8000, 1, "R6");
    look(32'h1000_8007, "R5");
    fill(32'h2000_0010, 2, "R6");
    // R8: refill of resident tag during empty phase
    fill(32'h1000_800F, 3, "R8");
    fill(32'h3000_0020, 4, "R6");
    fill(32'h1000_8010, 5, "R6");

    // R2 R3 R4: every offset of every line
    for (int l = 0; l < N; l++)
      for (int o = 0; o < 16; o++)
        look({m_tag[l], 4'(o)}, "R2");
    // R3: near-miss tags
    look(32'h1000_8020, "R3");
    look(32'h0000_8000, "R3");
    look(32'h9000_8000, "R3");

    // R7: new tags beyond capacity rotate through slots
    for (int j = 0; j < 7; j++) begin
      fill(32'h4000_0000 + 32'(j) * 32'h100, 10 + j, "R7");
      look(32'h4000_0003 + 32'(j) * 32'h100, "R7");
    end
    // evicted tags miss
    look(32'h1000_8000, "R7");
    look(32'h2000_0010, "R7");
    // R8: refill resident tag in full phase, pointer not moved
    fill(32'h4000_0600, 30, "R8");
    look(32'h4000_060A, "R8");
    fill(32'h5000_0000, 31, "R7");
    // R9: slot shown for a pending address without fill
    @(negedge clk);
    fill_addr = 32'h4000_0500;
    #1;
    check("R9 slot dup", fill_slot, model_slot(28'h400_0050));
    fill_addr = 32'h7777_0000;
    #1;
    check("R9 slot new", fill_slot, model_slot(28'h777_7000));
    for (int l = 0; l < N; l++)
      for (int o = 0; o < 16; o += 5)
        look({m_tag[l], 4'(o)}, "R2");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      #(CLK_PERIOD * 20000);
    join_any
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule